// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is an 8192-bit on-chip memory with one port that only writes and one that only reads. The two ports may see the array at different word widths (1, 2, 4, 8, 16 or 32 bits), so a producer can fill it in wide words while a consumer drains it narrow, or the reverse. Each port runs on its own clock and has its own clock enable. Each port can also freeze its address with a stall input.

A wide word and the narrow words it contains are tied by a little-endian rule. The narrow word with the smallest address sits in the least significant bits of the wide word. Writes of 16 or 32 bits carry one enable per byte. The read data can come straight from the array capture register or pass through one more output register, chosen by a parameter. An asynchronous clear zeroes the read-data registers and leaves the stored contents alone.

Top module: `mixed_width_ram`

## Requirements
- R1: With write width W and read width N (W > N, ratio R = W/N), read address A*R+k returns bits [N*k+N-1 : N*k] of the write word at address A, for k from 0 to R-1.
- R2: For a 32-bit write, byte enable bit i (wr_be[i]) gates write data bits [8i+7:8i]. Bytes whose enable is 0 keep their old contents.
- R3: A write and a read in the same clock cycle to different words both complete. A read that hits the word being written in that cycle returns the contents from before the write.
- R4: With OUT_REG=1, read data appears on rd_q after the second rising read-clock edge that follows the address, and is not yet valid after the first edge.
- R5: While rd_en is 0, rd_q keeps its previous value even when rd_addr changes.
- R6: While wr_ce is 0, no write takes place. While rd_ce is 0, rd_q does not change.
- R7: While a port's stall input is 1, that port uses the last address it captured with its clock enable high and stall low, and it ignores its address input.
- R8: Raising aclr drives rd_q to 0 at once without waiting for a clock edge. The stored contents are not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| wr_ce | input | 1 | Write-port clock enable |
| wr_stall | input | 1 | Hold the last captured write address |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Per-byte write enables |
| rd_clk | input | 1 | Read-port clock |
| rd_ce | input | 1 | Read-port clock enable |
| rd_stall | input | 1 | Hold the last captured read address |
| rd_en | input | 1 | Read request |
| rd_addr | input | 10 | Read word address |
| aclr | input | 1 | Asynchronous clear of the read-data registers |
| rd_q | output | 8 | Read data |

## Verification
The clocked properties assume that aclr covers at least one rising edge whenever it pulses. They also assume that no write or read fires before the first edge after aclr is released. The properties are judged against a single time base, so the bench drives both port clocks from one 125 MHz source. Stimulus changes only on falling edges and drops aclr on a falling edge. Every word the bench reads has been written in full beforehand, so no check depends on contents that were never initialized. The same-word read-during-write case is exercised only with both clocks in phase.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  // Index of the storage word that holds a given port address.
  function automatic int unsigned word_of(int unsigned addr, int unsigned ratio);
    return addr / ratio;
  endfunction

  // Position of a port word inside its storage word (0 = least significant).
  function automatic int unsigned lane_of(int unsigned addr, int unsigned ratio);
    return addr % ratio;
  endfunction

  function automatic int unsigned wider(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Byte lanes only exist for write words of 16 bits and up.
  function automatic int unsigned be_lanes(int unsigned w);
    return (w >= 16) ? w / 8 : 1;
  endfunction

endpackage

// File: rtl/mwram_wr_port.sv
module mwram_wr_port
  import mwram_pkg::*;
#(
  parameter int unsigned WR_W   = 32,
  parameter int unsigned MAXW   = 32,
  parameter int unsigned RATIO  = 1,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              stall,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WR_W-1:0]   data,
  input  logic [BE_W-1:0]   be,
  output logic              fire,
  output logic [IDX_W-1:0]  idx,
  output logic [MAXW-1:0]   word,
  output logic [MAXW-1:0]   mask
);

  logic [ADDR_W-1:0] held_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [WR_W-1:0]   bit_en;
  int unsigned       wshift;

  assign eff_addr = stall ? held_addr : addr;

  always_ff @(posedge clk) begin
    if (ce && !stall) held_addr <= addr;
  end

  // One enable bit per data bit; writes narrower than 16 bits share be[0].
  for (genvar g = 0; g < WR_W; g++) begin : g_bit_en
    assign bit_en[g] = be[g / 8];
  end

  assign wshift = lane_of(32'(eff_addr), RATIO) * WR_W;
  assign idx    = IDX_W'(word_of(32'(eff_addr), RATIO));
  assign word   = MAXW'(data) << wshift;
  assign mask   = MAXW'(bit_en) << wshift;
  assign fire   = ce && en;

endmodule

// File: rtl/mwram_store.sv
module mwram_store #(
  parameter int unsigned MAXW  = 32,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic             wr_clk,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [MAXW-1:0]  wr_word,
  input  logic [MAXW-1:0]  wr_mask,
  input  logic             rd_clk,
  input  logic             rd_fire,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             aclr,
  output logic [MAXW-1:0]  rd_word
);

  logic [MAXW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem[wr_idx] <= (mem[wr_idx] & ~wr_mask) | (wr_word & wr_mask);
  end

  // Nonblocking capture: a same-edge write to this word is not yet visible.
  always_ff @(posedge rd_clk or posedge aclr) begin
    if (aclr)         rd_word <= '0;
    else if (rd_fire) rd_word <= mem[rd_idx];
  end

  // R2
  masked_write_chk: assert property (@(posedge wr_clk) disable iff (aclr)
    wr_fire |=> (((mem[$past(wr_idx)] ^ $past(wr_word)) & $past(wr_mask)) == '0));

endmodule

// File: rtl/mwram_rd_port.sv
module mwram_rd_port
  import mwram_pkg::*;
#(
  parameter int unsigned RD_W    = 8,
  parameter int unsigned MAXW    = 32,
  parameter int unsigned RATIO   = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned LANE_W  = 2,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              stall,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aclr,
  input  logic [MAXW-1:0]   rd_word,
  output logic              fire,
  output logic [IDX_W-1:0]  idx,
  output logic [RD_W-1:0]   q
);

  logic [ADDR_W-1:0] held_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANE_W-1:0] lane_q;
  logic [RD_W-1:0]   ram_q;

  assign eff_addr = stall ? held_addr : addr;
  assign fire     = ce && en;
  assign idx      = IDX_W'(word_of(32'(eff_addr), RATIO));

  always_ff @(posedge clk) begin
    if (ce && !stall) held_addr <= addr;
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      lane_q <= '0;
    else if (fire) lane_q <= LANE_W'(lane_of(32'(eff_addr), RATIO));
  end

  assign ram_q = rd_word[lane_q * RD_W +: RD_W];

  if (OUT_REG) begin : g_out_reg
    logic [RD_W-1:0] q_reg;
    always_ff @(posedge clk or posedge aclr) begin
      if (aclr)    q_reg <= '0;
      else if (ce) q_reg <= ram_q;
    end
    assign q = q_reg;

    // R4
    out_stage_delay_chk: assert property (@(posedge clk) disable iff (aclr)
      ce |=> (q == $past(ram_q)));
  end else begin : g_out_direct
    assign q = ram_q;
  end

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (aclr)
    (ce && !en) |=> $stable(ram_q));

  // R6
  rd_freeze_chk: assert property (@(posedge clk) disable iff (aclr)
    !ce |=> $stable(q));

  // R8
  clear_zero_chk: assert property (@(posedge clk) aclr |-> (q == '0));

endmodule

// File: rtl/mixed_width_ram.sv
module mixed_width_ram
  import mwram_pkg::*;
#(
  parameter int unsigned WR_W       = 32,
  parameter int unsigned RD_W       = 8,
  parameter int unsigned TOTAL_BITS = 8192,
  parameter bit          OUT_REG    = 1'b1,
  localparam int unsigned WA_W = $clog2(TOTAL_BITS / WR_W),
  localparam int unsigned RA_W = $clog2(TOTAL_BITS / RD_W),
  localparam int unsigned BE_W = be_lanes(WR_W)
) (
  input  logic            wr_clk,
  input  logic            wr_ce,
  input  logic            wr_stall,
  input  logic            wr_en,
  input  logic [WA_W-1:0] wr_addr,
  input  logic [WR_W-1:0] wr_data,
  input  logic [BE_W-1:0] wr_be,
  input  logic            rd_clk,
  input  logic            rd_ce,
  input  logic            rd_stall,
  input  logic            rd_en,
  input  logic [RA_W-1:0] rd_addr,
  input  logic            aclr,
  output logic [RD_W-1:0] rd_q
);

  localparam int unsigned MAXW   = wider(WR_W, RD_W);
  localparam int unsigned DEPTH  = TOTAL_BITS / MAXW;
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned WR_R   = MAXW / WR_W;
  localparam int unsigned RD_R   = MAXW / RD_W;
  localparam int unsigned LANE_W = (RD_R > 1) ? $clog2(RD_R) : 1;

  logic             w_fire;
  logic [IDX_W-1:0] w_idx;
  logic [MAXW-1:0]  w_word;
  logic [MAXW-1:0]  w_mask;
  logic             r_fire;
  logic [IDX_W-1:0] r_idx;
  logic [MAXW-1:0]  r_word;

  mwram_wr_port #(
    .WR_W(WR_W), .MAXW(MAXW), .RATIO(WR_R),
    .ADDR_W(WA_W), .IDX_W(IDX_W), .BE_W(BE_W)
  ) u_wr (
    .clk(wr_clk), .ce(wr_ce), .stall(wr_stall), .en(wr_en),
    .addr(wr_addr), .data(wr_data), .be(wr_be),
    .fire(w_fire), .idx(w_idx), .word(w_word), .mask(w_mask)
  );

  mwram_store #(
    .MAXW(MAXW), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_store (
    .wr_clk(wr_clk), .wr_fire(w_fire), .wr_idx(w_idx),
    .wr_word(w_word), .wr_mask(w_mask),
    .rd_clk(rd_clk), .rd_fire(r_fire), .rd_idx(r_idx),
    .aclr(aclr), .rd_word(r_word)
  );

  mwram_rd_port #(
    .RD_W(RD_W), .MAXW(MAXW), .RATIO(RD_R), .ADDR_W(RA_W),
    .IDX_W(IDX_W), .LANE_W(LANE_W), .OUT_REG(OUT_REG)
  ) u_rd (
    .clk(rd_clk), .ce(rd_ce), .stall(rd_stall), .en(rd_en),
    .addr(rd_addr), .aclr(aclr), .rd_word(r_word),
    .fire(r_fire), .idx(r_idx), .q(rd_q)
  );

endmodule

// File: tb/mixed_width_ram_test.sv
module mixed_width_ram_test;

  logic        clk = 1'b0;
  logic        wr_ce = 1'b1, wr_stall = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_ce = 1'b1, rd_stall = 1'b0, rd_en = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic        aclr = 1'b0;
  logic [7:0]  rd_q;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [256];

  always #4 clk = ~clk;

  mixed_width_ram uut (
    .wr_clk(clk), .wr_ce(wr_ce), .wr_stall(wr_stall), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_clk(clk), .rd_ce(rd_ce), .rd_stall(rd_stall), .rd_en(rd_en),
    .rd_addr(rd_addr), .aclr(aclr), .rd_q(rd_q)
  );

  // {word address, data, byte enables}
  localparam logic [43:0] VEC [8] = '{
    {8'd3,   32'h1122_3344, 4'hF},
    {8'd3,   32'hAABB_CCDD, 4'h5},
    {8'd200, 32'hDEAD_BEEF, 4'hF},
    {8'd200, 32'h0000_0000, 4'h8},
    {8'd0,   32'h0102_0304, 4'hF},
    {8'd255, 32'hCAFE_F00D, 4'hF},
    {8'd255, 32'h1234_5678, 4'h0},
    {8'd0,   32'hFFFF_FFFF, 4'h2}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] narrow(input int n);
    logic [31:0] w = model[n >> 2];
    return w[(n & 3) * 8 +: 8];
  endfunction

  task automatic model_write(input int a, input logic [31:0] d, input logic [3:0] be);
    for (int i = 0; i < 4; i++)
      if (be[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d, be);
  endtask

  task automatic do_read(input int n);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 10'(n);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1 aclr = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset", rd_q, 8'h00);
    aclr = 1'b0;

    // table walk: R1, R2
    for (int v = 0; v < 8; v++) begin
      do_write(int'(VEC[v][43:36]), VEC[v][35:4], VEC[v][3:0]);
      for (int k = 0; k < 4; k++) begin
        do_read(int'(VEC[v][43:36]) * 4 + k);
        check(VEC[v][3:0] == 4'hF ? "R1 mapping" : "R2 byte enable",
              rd_q, narrow(int'(VEC[v][43:36]) * 4 + k));
      end
    end

    // R4: one edge is not enough, two edges deliver
    do_read(2);
    check("R4 setup", rd_q, narrow(2));
    @(negedge clk); rd_en = 1'b1; rd_addr = 10'd1;
    @(negedge clk); rd_en = 1'b0;
    check("R4 not yet", rd_q, narrow(2));
    @(negedge clk);
    check("R4 latency", rd_q, narrow(1));

    // R5: enable low holds output
    rd_addr = 10'd12;
    repeat (2) @(negedge clk);
    check("R5 hold", rd_q, narrow(1));

    // R6: read clock enable low freezes output
    rd_ce = 1'b0; rd_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 rd_ce", rd_q, narrow(1));
    rd_ce = 1'b1; rd_en = 1'b0;

    // R6: write clock enable low blocks write
    @(negedge clk);
    wr_ce = 1'b0; wr_en = 1'b1; wr_addr = 8'd3; wr_data = 32'h0; wr_be = 4'hF;
    @(negedge clk);
    wr_en = 1'b0; wr_ce = 1'b1;
    do_read(13);
    check("R6 wr_ce", rd_q, narrow(13));

    // R7: read address stall
    do_read(12);
    @(negedge clk); rd_addr = 10'd0;
    @(negedge clk); rd_stall = 1'b1; rd_addr = 10'd12; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; rd_stall = 1'b0;
    @(negedge clk);
    check("R7 rd stall", rd_q, narrow(0));

    // R7: write address stall
    do_write(20, 32'h5566_7788, 4'hF);
    @(negedge clk);
    wr_addr = 8'd21; wr_stall = 1'b1; wr_en = 1'b1; wr_data = 32'h9A9B_9C9D; wr_be = 4'hF;
    @(negedge clk);
    wr_en = 1'b0; wr_stall = 1'b0;
    model_write(20, 32'h9A9B_9C9D, 4'hF);
    do_read(80);
    check("R7 wr stall", rd_q, narrow(80));
    do_read(83);
    check("R7 wr stall", rd_q, narrow(83));

    // R3: same cycle, different words
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd30; wr_data = 32'h0F1E_2D3C; wr_be = 4'hF;
    rd_en = 1'b1; rd_addr = 10'd14;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    model_write(30, 32'h0F1E_2D3C, 4'hF);
    check("R3 parallel read", rd_q, narrow(14));
    do_read(121);
    check("R3 parallel write", rd_q, narrow(121));

    // R3: same word returns old contents
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd3; wr_data = 32'h7777_7777; wr_be = 4'hF;
    rd_en = 1'b1; rd_addr = 10'd12;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    check("R3 old data", rd_q, narrow(12));
    model_write(3, 32'h7777_7777, 4'hF);
    do_read(12);
    check("R3 new data", rd_q, narrow(12));

    // R8: async clear, contents kept
    @(negedge clk); aclr = 1'b1;
    #1 check("R8 async clear", rd_q, 8'h00);
    @(negedge clk); aclr = 1'b0;
    do_read(1);
    check("R8 contents kept", rd_q, narrow(1));
    do_read(803);
    check("R8 contents kept", rd_q, narrow(803));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule